// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers event pulses into three 8-bit sticky status registers. Each status register has an 8-bit mask register beside it. Software reaches all six through a small register port that has an address, a write strobe and a read strobe. Any status bit that is set while its mask bit is clear pulls a single active-low interrupt line. The interrupt line comes from a register. Software finds the cause by reading the status registers. Each read returns the pending bits and empties that register in the same access.

An event that arrives in the same cycle as the read that clears its register is kept. Each mask register keeps only its own fixed set of writable bits. Reading the second mask register clears its two lowest bits. A once-per-second tick input has a fixed place in the first status register.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, status register 0 (address 0) reads 0x01, status register 1 (address 1) reads 0x01, status register 2 (address 2) reads 0x00, and mask registers 0..2 (addresses 3, 4, 5) read 0x00. The interrupt line is low, because status register 0 bit 0 is pending.
- R2: A one-cycle pulse on bit i of evt_a, evt_b or evt_c sets bit i of status register 0, 1 or 2 respectively. Bits set by separate pulses accumulate.
- R3: A one-cycle pulse on sec_tick sets bit 6 of status register 0.
- R4: A read (rd_en high) at a status address returns that register's current value on rd_data in the same cycle. From the next cycle on, the register holds zero, apart from bits set by events in the read cycle.
- R5: An event bit that is pulsed in the same cycle as a read of its status register is not returned by that read. That bit is present in the register after the read.
- R6: A write (wr_en high) to mask register 0 stores wr_data AND 0xDF. A write to mask register 1 stores all eight bits. A write to mask register 2 stores wr_data AND 0xCF.
- R7: A read of mask register 1 returns its value and then clears its bits 1 and 0. Reads of mask registers 0 and 2 leave them unchanged.
- R8: irq_n is registered. One cycle after the register state shows any status bit set with its mask bit clear, irq_n is 0. Otherwise irq_n is 1 one cycle later.
- R9: Writes to status addresses 0..2 and to unmapped addresses 6..7 change no register. Reads of addresses 6..7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid in the cycle rd_en is high |
| evt_a | input | 8 | Event pulses for status register 0 |
| evt_b | input | 8 | Event pulses for status register 1 |
| evt_c | input | 8 | Event pulses for status register 2 |
| sec_tick | input | 1 | Once-per-second tick pulse |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Mask writes use an all-ones value, so each register's writable-bit pattern shows in full, and the read-back shows which bits it dropped. Repeated reads of each mask register separate the self-clearing register from the two that keep their value. They also separate clear-on-read status from plain reads.

Status is built in several ways:
- Events spread over separate pulses show that bits accumulate.
- An event timed onto the reading cycle shows the difference between losing the bit and keeping it.
- A masked event and an unmasked event, each followed by a mask change, are sampled at both the first and the second cycle. This shows the single cycle of lag on the interrupt line and its polarity.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 3;
    localparam int ADDR_W   = 3;

    localparam int STAT_BASE = 0;
    localparam int MASK_BASE = STAT_BASE + NUM_REGS;
    localparam int TICK_BIT  = 6;

    typedef logic [DATA_W-1:0] word_t;

    localparam word_t STAT_RST   [NUM_REGS] = '{8'h01, 8'h01, 8'h00};
    localparam word_t MASK_KEEP  [NUM_REGS] = '{8'hDF, 8'hFF, 8'hCF};
    localparam word_t MASK_RDCLR [NUM_REGS] = '{8'h00, 8'h03, 8'h00};

    // The interrupt line is low after reset whenever any reset status bit is set.
    function automatic logic irq_rst_level();
        logic any;
        any = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            any = any | (|STAT_RST[i]);
        end
        return ~any;
    endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  RST_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] evt,
    output logic [DATA_W-1:0] stat
);
    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_hit) begin
            st_d.bits = evt;
        end else begin
            st_d.bits = st_q.bits | evt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bits <= RST_VAL[DATA_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.bits;

    // R2: without a read, no set bit is lost and every event bit lands
    a_r2_sticky_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> ((stat & ($past(stat) | $past(evt))) == ($past(stat) | $past(evt))));

    // R4: after a read, only bits from the read cycle's events remain
    a_r4_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> ((stat & ~$past(evt)) == '0));

    // R5: events coinciding with the read survive it
    a_r5_evt_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && (evt != '0)) |=> ((stat & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  KEEP   = 8'hFF,
    parameter logic [7:0]  RDCLR  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mask
);
    localparam logic [DATA_W-1:0] KEEP_W  = KEEP[DATA_W-1:0];
    localparam logic [DATA_W-1:0] RDCLR_W = RDCLR[DATA_W-1:0];

    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } mask_state_t;

    mask_state_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (wr_hit) begin
            mk_d.bits = wr_data & KEEP_W;
        end else if (rd_hit) begin
            mk_d.bits = mk_q.bits & ~RDCLR_W;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mk_q.bits <= '0;
        end else begin
            mk_q <= mk_d;
        end
    end

    assign mask = mk_q.bits;

    // R6: a stored mask holds only writable bits of the written value
    a_r6_write_filter: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (mask == ($past(wr_data) & KEEP_W)));

    // R7: a read drops only the self-clearing bits
    a_r7_read_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !wr_hit) |=> (mask == ($past(mask) & ~RDCLR_W)));

    // R9: with no write, nothing outside the read-clear set changes
    a_r9_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ((mask & ~RDCLR_W) == ($past(mask) & ~RDCLR_W)));
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
    parameter int   DATA_W    = 8,
    parameter int   NUM_REGS  = 3,
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS*DATA_W-1:0] stat_flat,
    input  logic [NUM_REGS*DATA_W-1:0] mask_flat,
    output logic                       irq_n
);
    typedef struct packed {
        logic line_n;
    } line_state_t;

    line_state_t ln_d, ln_q;
    logic        pending;

    always_comb begin
        pending   = |(stat_flat & ~mask_flat);
        ln_d      = ln_q;
        ln_d.line_n = ~pending;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q.line_n <= RST_LEVEL;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign irq_n = ln_q.line_n;

    // R8: the line reflects last cycle's unmasked pending state
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n == ~|($past(stat_flat) & ~$past(mask_flat))));
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] evt_a,
    input  logic [DATA_W-1:0] evt_b,
    input  logic [DATA_W-1:0] evt_c,
    input  logic              sec_tick,
    output logic              irq_n
);
    localparam int   FLAT_W    = NUM_REGS * DATA_W;
    localparam logic IRQ_RST_N = irq_rst_level();

    logic [FLAT_W-1:0] evt_flat;
    logic [FLAT_W-1:0] stat_flat;
    logic [FLAT_W-1:0] mask_flat;
    logic [DATA_W-1:0] tick_vec;

    always_comb begin
        tick_vec           = '0;
        tick_vec[TICK_BIT] = sec_tick;
        evt_flat           = {evt_c, evt_b, evt_a | tick_vec};
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_pair
        logic st_rd, mk_rd, mk_wr;

        assign st_rd = rd_en && (addr == ADDR_W'(STAT_BASE + g));
        assign mk_rd = rd_en && (addr == ADDR_W'(MASK_BASE + g));
        assign mk_wr = wr_en && (addr == ADDR_W'(MASK_BASE + g));

        irq_status_reg #(
            .DATA_W  (DATA_W),
            .RST_VAL (STAT_RST[g])
        ) u_stat (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_hit (st_rd),
            .evt    (evt_flat[g*DATA_W +: DATA_W]),
            .stat   (stat_flat[g*DATA_W +: DATA_W])
        );

        irq_mask_reg #(
            .DATA_W (DATA_W),
            .KEEP   (MASK_KEEP[g]),
            .RDCLR  (MASK_RDCLR[g])
        ) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (mk_wr),
            .rd_hit  (mk_rd),
            .wr_data (wr_data),
            .mask    (mask_flat[g*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (addr == ADDR_W'(STAT_BASE + i)) rd_data = stat_flat[i*DATA_W +: DATA_W];
                if (addr == ADDR_W'(MASK_BASE + i)) rd_data = mask_flat[i*DATA_W +: DATA_W];
            end
        end
    end

    irq_line_drv #(
        .DATA_W    (DATA_W),
        .NUM_REGS  (NUM_REGS),
        .RST_LEVEL (IRQ_RST_N)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_flat (stat_flat),
        .mask_flat (mask_flat),
        .irq_n     (irq_n)
    );

    // R9: unmapped addresses read as zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr >= ADDR_W'(MASK_BASE + NUM_REGS))) |-> (rd_data == '0));

    // R3: a tick lands in status register 0 bit 6
    a_r3_tick_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> stat_flat[STAT_BASE*DATA_W + TICK_BIT]);
endmodule

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] evt_a = '0, evt_b = '0, evt_c = '0;
    logic       sec_tick = 1'b0;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_status_agg dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .evt_a(evt_a), .evt_b(evt_b),
        .evt_c(evt_c), .sec_tick(sec_tick), .irq_n(irq_n)
    );

    // entry: {write, addr[2:0], data[7:0], expected[7:0], req[3:0]}
    localparam int NV = 19;
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h00, 8'h01, 4'd1},  // R1 status 0 reset
        {1'b0, 3'd0, 8'h00, 8'h00, 4'd4},  // R4 cleared by the read
        {1'b0, 3'd1, 8'h00, 8'h01, 4'd1},  // R1 status 1 reset
        {1'b0, 3'd2, 8'h00, 8'h00, 4'd1},  // R1 status 2 reset
        {1'b0, 3'd3, 8'h00, 8'h00, 4'd1},  // R1 masks reset
        {1'b0, 3'd4, 8'h00, 8'h00, 4'd1},
        {1'b0, 3'd5, 8'h00, 8'h00, 4'd1},
        {1'b1, 3'd3, 8'hFF, 8'h00, 4'd6},  // R6 mask 0 keeps 0xDF
        {1'b0, 3'd3, 8'h00, 8'hDF, 4'd6},
        {1'b1, 3'd4, 8'hFF, 8'h00, 4'd6},  // R6 mask 1 keeps all
        {1'b0, 3'd4, 8'h00, 8'hFF, 4'd6},
        {1'b0, 3'd4, 8'h00, 8'hFC, 4'd7},  // R7 low bits self-cleared
        {1'b1, 3'd5, 8'hFF, 8'h00, 4'd6},  // R6 mask 2 keeps 0xCF
        {1'b0, 3'd5, 8'h00, 8'hCF, 4'd6},
        {1'b0, 3'd5, 8'h00, 8'hCF, 4'd7},  // R7 mask 2 not self-clearing
        {1'b1, 3'd0, 8'hAA, 8'h00, 4'd9},  // R9 status write ignored
        {1'b0, 3'd0, 8'h00, 8'h00, 4'd9},
        {1'b0, 3'd6, 8'h00, 8'h00, 4'd9},  // R9 unmapped reads zero
        {1'b0, 3'd7, 8'h00, 8'h00, 4'd9}
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, input int req, input logic [7:0] exp);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 check(req, rd_data, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check(1, {7'd0, irq_n}, 8'h00);  // R1 irq low after reset

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][23]) do_write(VEC[i][22:20], VEC[i][19:12]);
            else            do_read(VEC[i][22:20], int'(VEC[i][3:0]), VEC[i][11:4]);
        end

        // R9: unmapped write leaves mask 0 unchanged
        do_write(3'd6, 8'h00);
        do_read(3'd3, 9, 8'hDF);

        // R2: separate pulses accumulate in status 1
        @(negedge clk); evt_b = 8'h05;
        @(negedge clk); evt_b = 8'h30;
        @(negedge clk); evt_b = 8'h00;
        do_read(3'd1, 2, 8'h35);

        // R3: tick sets bit 6 of status 0
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        do_read(3'd0, 3, 8'h40);

        // R5: event in read cycle survives
        @(negedge clk); evt_c = 8'h01;
        @(negedge clk); evt_c = 8'h08; addr = 3'd2; rd_en = 1'b1;
        #1 check(5, rd_data, 8'h01);
        @(negedge clk); evt_c = 8'h00; rd_en = 1'b0;
        do_read(3'd2, 5, 8'h08);

        // R8: all clear now, masks 0xDF/0xFC/0xCF
        @(negedge clk); #1 check(8, {7'd0, irq_n}, 8'h01);
        evt_a = 8'h20;  // bit 5 unmaskable in mask 0
        @(negedge clk); evt_a = 8'h00;
        #1 check(8, {7'd0, irq_n}, 8'h01);  // one-cycle lag
        @(negedge clk); #1 check(8, {7'd0, irq_n}, 8'h00);
        do_read(3'd0, 8, 8'h20);
        #1 check(8, {7'd0, irq_n}, 8'h00);
        @(negedge clk); #1 check(8, {7'd0, irq_n}, 8'h01);

        // R8: masked event keeps the line high, unmasking lowers it
        evt_a = 8'h01;
        @(negedge clk); evt_a = 8'h00;
        @(negedge clk); #1 check(8, {7'd0, irq_n}, 8'h01);
        do_write(3'd3, 8'h00);
        #1 check(8, {7'd0, irq_n}, 8'h01);
        @(negedge clk); #1 check(8, {7'd0, irq_n}, 8'h00);
        do_read(3'd0, 4, 8'h01);
        @(negedge clk); #1 check(8, {7'd0, irq_n}, 8'h01);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule